// File: doc/BRIEF.md
# Block-Floating-Point Pass Scaler for an In-Place Radix-2 FFT

This block holds the scaling decision for an in-place radix-2 FFT that sweeps a stored frame once per stage. The butterfly datapath sends it every sum and difference it produces. Each result arrives one bit wider than the stored word, so one guard bit is kept. The block checks every lane of every accepted result against the stored width and keeps a sticky flag for the current pass. When the pass closes, that flag decides whether the datapath must shift every operand right by one bit as it reads the array on the next pass. The array is never rewritten just to scale it. After the last stage, a pending halving stays requested so that the output stage can apply it.

Every halving adds one to a frame exponent. That exponent is the only floating-point part of an otherwise fixed-point transform. A halving is only requested for a pass in which an overflow was actually seen, because each halving costs output signal-to-noise ratio.

The controller is a four-state machine:
- IDLE is the state after reset.
- READY waits for a pass to begin.
- PASS collects overflow results.
- DONE is reached after the last of the LOG2N passes.

Its transitions are:
- IDLE→READY on frame start.
- READY→PASS on pass start.
- PASS→READY on pass end for a pass that is not the last.
- PASS→DONE on pass end for the last pass.
- Any state→READY on frame start.

Top module: `bfp_scaler`

## Requirements
- R1: After reset, shift_en, exponent, pass_ovf and frame_done are all 0, and the controller is in IDLE.
- R2: A lane of res_data is a two's-complement value of DATA_W+1 bits. Lane i occupies bits [i*(DATA_W+1) +: DATA_W+1]. The lane overflows when its value lies outside [-2^(DATA_W-1), 2^(DATA_W-1)-1]. Any lane overflowing in an accepted result counts as an overflow.
- R3: In PASS, an accepted result (res_valid=1) with an overflow sets pass_ovf on the next cycle. pass_ovf then stays 1 until it is cleared.
- R4: A pass_start accepted in READY clears pass_ovf on the next cycle.
- R5: On pass_end in PASS, shift_en takes the value 1 if an overflow was seen in that pass, counting a result accepted in the same cycle as pass_end, and 0 otherwise. shift_en then holds until the next pass_end in PASS or the next frame_start.
- R6: The exponent rises by exactly one on each pass_end of a pass that saw an overflow. Otherwise it holds.
- R7: The LOG2N-th pass_end of a frame moves the controller to DONE, where frame_done=1. shift_en keeps its final value there for the output stage.
- R8: frame_start in any state clears the exponent, shift_en, pass_ovf and the pass count, and moves the controller to READY. It takes priority over the other strobes in the same cycle.
- R9: res_valid outside PASS, pass_start outside READY and pass_end outside PASS have no effect on any output.
- R10: The exponent never exceeds LOG2N, even when every pass overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Pulse that begins a new frame |
| pass_start | input | 1 | Pulse that begins one stage pass |
| pass_end | input | 1 | Pulse that closes the current pass |
| res_valid | input | 1 | res_data carries butterfly results this cycle |
| res_data | input | LANES*(DATA_W+1) | Butterfly sum/difference lanes, each with one guard bit |
| shift_en | output | 1 | Halve operands read in the next pass, or at the output after the last pass |
| exponent | output | $clog2(LOG2N+1) | Number of halvings applied to the frame |
| pass_ovf | output | 1 | Sticky overflow flag of the current pass |
| frame_done | output | 1 | All LOG2N passes of the frame have closed |

## Verification
The corner that is hardest to reach from the ports is an overflow that arrives in the very cycle that closes a pass. That overflow has not yet reached pass_ovf, but it must still set shift_en and the exponent. The stimulus places an out-of-range lane on the pass_end cycle of chosen passes. It also places values exactly on both range limits in different lanes, so that the detection edge is exercised from both sides. A separate frame overflows in every one of its passes, runs into DONE and keeps pulsing strobes there, to reach the exponent ceiling. Strobes sent in the wrong states, and a frame restart in the middle of a pass, cover the priority and ignore rules.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_PASS  = 2'd2,
        ST_DONE  = 2'd3
    } bfp_state_e;

endpackage

// File: rtl/bfp_lane_check.sv
module bfp_lane_check #(
    parameter int DATA_W = 16,
    parameter int LANES  = 4
) (
    input  logic [LANES*(DATA_W+1)-1:0] res_data,
    output logic                        any_ovf
);
    localparam int LW = DATA_W + 1;

    logic [LANES-1:0] lane_ovf;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            // guard bit and stored sign bit disagree -> not representable
            assign lane_ovf[g] = res_data[g*LW + DATA_W] ^ res_data[g*LW + DATA_W - 1];
        end
    endgenerate

    assign any_ovf = |lane_ovf;

endmodule

// File: rtl/bfp_exp_counter.sv
module bfp_exp_counter #(
    parameter int LIMIT = 10,
    parameter int W     = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc && (value < W'(LIMIT))) begin
            value <= value + W'(1);
        end
    end

endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler
    import bfp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LOG2N  = 10,
    parameter int LANES  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             frame_start,
    input  logic                             pass_start,
    input  logic                             pass_end,
    input  logic                             res_valid,
    input  logic [LANES*(DATA_W+1)-1:0]      res_data,
    output logic                             shift_en,
    output logic [$clog2(LOG2N+1)-1:0]       exponent,
    output logic                             pass_ovf,
    output logic                             frame_done
);
    localparam int EXP_W = $clog2(LOG2N + 1);
    localparam int CNT_W = $clog2(LOG2N + 1);

    bfp_state_e       state_q, state_d;
    logic             any_ovf;
    logic             hit;
    logic             pass_close;
    logic             last_pass;
    logic             seen_ovf;
    logic             sticky_q;
    logic             shift_q;
    logic [CNT_W-1:0] pass_cnt_q;

    bfp_lane_check #(.DATA_W(DATA_W), .LANES(LANES)) u_check (
        .res_data (res_data),
        .any_ovf  (any_ovf)
    );

    assign hit        = res_valid && (state_q == ST_PASS) && any_ovf;
    assign seen_ovf   = sticky_q || hit;
    assign pass_close = pass_end && (state_q == ST_PASS) && !frame_start;
    assign last_pass  = (pass_cnt_q == CNT_W'(LOG2N - 1));

    bfp_exp_counter #(.LIMIT(LOG2N), .W(EXP_W)) u_exp (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_start),
        .inc   (pass_close && seen_ovf),
        .value (exponent)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_IDLE;
            ST_READY: if (pass_start) state_d = ST_PASS;
            ST_PASS:  if (pass_end) state_d = last_pass ? ST_DONE : ST_READY;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
        if (frame_start) state_d = ST_READY;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output / flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q   <= 1'b0;
            shift_q    <= 1'b0;
            pass_cnt_q <= '0;
        end else if (frame_start) begin
            sticky_q   <= 1'b0;
            shift_q    <= 1'b0;
            pass_cnt_q <= '0;
        end else begin
            if ((state_q == ST_READY) && pass_start) sticky_q <= 1'b0;
            else if (hit)                            sticky_q <= 1'b1;
            if (pass_close) begin
                shift_q    <= seen_ovf;
                pass_cnt_q <= pass_cnt_q + CNT_W'(1);
            end
        end
    end

    assign shift_en   = shift_q;
    assign pass_ovf   = sticky_q;
    assign frame_done = (state_q == ST_DONE);

    // ---------------- assertions ----------------
    a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_ovf && !pass_start && !frame_start) |=> pass_ovf);

    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && pass_start && !frame_start) |=> !pass_ovf);

    a_r5_shift_stable_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PASS && !pass_end && !frame_start) |=> $stable(shift_en));

    a_r6_exp_step: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (exponent == $past(exponent) || exponent == $past(exponent) + EXP_W'(1)));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_start) |=> (frame_done && $stable(shift_en) && $stable(exponent)));

    a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (exponent == '0 && !shift_en && !pass_ovf && !frame_done));

    a_r10_exp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        exponent <= EXP_W'(LOG2N));

endmodule

// File: tb/tb_bfp_scaler.sv
`timescale 1ns/1ps
module tb_bfp_scaler;
    localparam int DW    = 16;
    localparam int L2N   = 10;
    localparam int LN    = 4;
    localparam int LW    = DW + 1;
    localparam int RES_W = LN * LW;
    localparam int EW    = $clog2(L2N + 1);
    localparam int MAXV  = 2**(DW-1) - 1;
    localparam int MINV  = -(2**(DW-1));

    logic clk = 0;
    logic rst_n = 0;
    logic frame_start = 0, pass_start = 0, pass_end = 0, res_valid = 0;
    logic [RES_W-1:0] res_data = '0;
    logic shift_en, pass_ovf, frame_done;
    logic [EW-1:0] exponent;

    int n_cmp = 0, n_bad = 0, cyc_cnt = 0;

    always #2.5 clk = ~clk;

    bfp_scaler #(.DATA_W(DW), .LOG2N(L2N), .LANES(LN)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pass_start(pass_start),
        .pass_end(pass_end), .res_valid(res_valid), .res_data(res_data),
        .shift_en(shift_en), .exponent(exponent), .pass_ovf(pass_ovf), .frame_done(frame_done)
    );

    // behavioural reference: 0 idle, 1 ready, 2 pass, 3 done
    int m_state = 0, m_cnt = 0, m_exp = 0;
    bit m_sticky = 0, m_shift = 0;

    function automatic bit ref_ovf(logic [RES_W-1:0] d);
        bit o = 0;
        for (int i = 0; i < LN; i++) begin
            logic signed [LW-1:0] s;
            int v;
            s = d[i*LW +: LW];
            v = int'(s);
            if (v > MAXV || v < MINV) o = 1;
        end
        return o;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_exp = 0; m_sticky = 0; m_shift = 0;
        end else if (frame_start) begin
            m_state = 1; m_cnt = 0; m_exp = 0; m_sticky = 0; m_shift = 0;
        end else begin
            case (m_state)
                1: if (pass_start) begin m_sticky = 0; m_state = 2; end
                2: begin
                    bit seen;
                    seen = m_sticky || (res_valid && ref_ovf(res_data));
                    m_sticky = seen;
                    if (pass_end) begin
                        m_shift = seen;
                        if (seen && m_exp < L2N) m_exp++;
                        m_cnt++;
                        m_state = (m_cnt == L2N) ? 3 : 1;
                    end
                end
                default: ;
            endcase
        end
    end

    task automatic chk(string req, int act, int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cyc_cnt++;
            chk("R5 shift_en", int'(shift_en), int'(m_shift));
            chk("R6 exponent", int'(exponent), m_exp);
            chk("R3 pass_ovf", int'(pass_ovf), int'(m_sticky));
            chk("R7 frame_done", int'(frame_done), int'(m_state == 3));
        end
    end

    function automatic logic [RES_W-1:0] mk(int ovf_lane, bit neg);
        logic [RES_W-1:0] d;
        for (int i = 0; i < LN; i++) begin
            int v;
            v = int'($urandom_range(0, 2**DW - 1)) + MINV;
            if (i == ovf_lane) v = neg ? MINV - 1 : MAXV + 1;
            d[i*LW +: LW] = v[LW-1:0];
        end
        return d;
    endfunction

    task automatic cyc(bit fs, bit ps, bit pe, bit v, logic [RES_W-1:0] d);
        frame_start = fs; pass_start = ps; pass_end = pe; res_valid = v; res_data = d;
        @(negedge clk);
        frame_start = 0; pass_start = 0; pass_end = 0; res_valid = 0; res_data = '0;
    endtask

    // ovf_idx: result index carrying an overflow (-1 none); end_ovf: overflow on the pass_end cycle
    task automatic run_pass(int nres, int ovf_idx, int lane, bit end_ovf);
        cyc(0, 1, 0, 0, '0);
        for (int k = 0; k < nres; k++)
            cyc(0, 0, 0, 1, mk(k == ovf_idx ? lane : -1, k[0]));
        cyc(0, 0, 1, end_ovf, mk(end_ovf ? lane : -1, 1'b1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 shift_en", int'(shift_en), 0);
        chk("R1 exponent", int'(exponent), 0);
        chk("R1 frame_done", int'(frame_done), 0);
        // R9 strobes and results in IDLE ignored
        cyc(0, 1, 0, 1, mk(2, 0));
        cyc(0, 0, 1, 1, mk(1, 1));
        chk("R9 idle pass_ovf", int'(pass_ovf), 0);
        chk("R9 idle exponent", int'(exponent), 0);

        // frame 1: mixed pattern
        cyc(1, 0, 0, 0, '0);
        run_pass(6, -1, 0, 0);
        chk("R5 clean pass no shift", int'(shift_en), 0);
        run_pass(6, 2, 3, 0);
        chk("R2 lane3 overflow seen", int'(pass_ovf), 1);
        chk("R6 exp after ovf pass", int'(exponent), 1);
        cyc(0, 1, 0, 0, '0);
        chk("R4 pass_start clears", int'(pass_ovf), 0);
        chk("R5 shift held into pass", int'(shift_en), 1);
        // exact boundary values: no overflow
        begin
            logic [RES_W-1:0] d;
            int hi, lo;
            hi = MAXV; lo = MINV;
            d = '0;
            d[0*LW +: LW] = hi[LW-1:0];
            d[1*LW +: LW] = lo[LW-1:0];
            d[2*LW +: LW] = lo[LW-1:0];
            d[3*LW +: LW] = hi[LW-1:0];
            cyc(0, 0, 0, 1, d);
            chk("R2 limits not overflow", int'(pass_ovf), 0);
        end
        cyc(0, 0, 1, 0, '0);
        chk("R5 shift drops after clean pass", int'(shift_en), 0);
        // R9 overflow result in READY ignored
        cyc(0, 0, 0, 1, mk(0, 1));
        cyc(0, 0, 1, 0, '0);
        chk("R9 ready result ignored", int'(pass_ovf), 0);
        run_pass(4, -1, 1, 1);
        chk("R5 overflow on pass_end cycle", int'(shift_en), 1);
        run_pass(5, 0, 0, 0);
        run_pass(5, 4, 1, 0);
        for (int p = 0; p < 3; p++) run_pass(3, -1, 0, 0);
        run_pass(3, 1, 2, 0);
        chk("R7 frame done", int'(frame_done), 1);
        chk("R7 output halving pending", int'(shift_en), 1);
        chk("R6 final exponent", int'(exponent), 5);

        // R8 restart mid-pass, with conflicting strobes
        cyc(1, 0, 0, 0, '0);
        run_pass(3, 0, 2, 0);
        cyc(0, 1, 0, 0, '0);
        cyc(0, 0, 0, 1, mk(1, 0));
        cyc(1, 1, 1, 1, mk(0, 0));
        chk("R8 exponent cleared", int'(exponent), 0);
        chk("R8 shift cleared", int'(shift_en), 0);
        chk("R8 pass_ovf cleared", int'(pass_ovf), 0);

        // R10 all passes overflow, then extra strobes in DONE
        for (int p = 0; p < L2N; p++) run_pass(2, p % 2, p % LN, 0);
        chk("R10 exponent at ceiling", int'(exponent), L2N);
        run_pass(2, 0, 0, 1);
        chk("R10 exponent stays", int'(exponent), L2N);
        chk("R9 done ignores pass", int'(frame_done), 1);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule